// File: doc/BRIEF.md
# Read-Only Instruction Cache Controller

This block sits between a 32-bit processor fetch port and a split command/response bus initiator. Every fetch is looked up in a set-associative array of tags and valid bits. When the fetch hits, the word comes back combinationally in the same cycle. When a cacheable fetch misses, the processor is held stalled while the block reads the whole line in one burst, stores it in a victim way, and then serves the fetch from the array. A fetch whose address falls in one of a small set of uncached windows is never looked up. Instead it is served by a direct one-word read that leaves the arrays untouched.

The processor keeps `fetch_req` and `fetch_addr` steady while `fetch_stall` is high. A cycle in which `fetch_req` is high and `fetch_stall` is low delivers `fetch_rdata` and `fetch_err`. The bus side issues one command beat (`cmd_val`/`cmd_ack`) that carries a word-aligned byte address and a length in words. It then accepts response beats (`rsp_val`/`rsp_ack`), and the last beat is marked by `rsp_eop`. Only one transaction is in flight at a time, and the block never writes. The geometry is set by parameters: lines per way (a power of two, 2 to 1024), words per line (a power of two, 2 to 32) and ways (a power of two, 1 to 16). The uncached windows are base/mask pairs, and an address matches a window when `(addr & mask) == base`.

Top module: `icache_ctl`

## Requirements
- R1: Reset invalidates every line, and `cmd_val`, `rsp_ack` and `fetch_stall` are low while no fetch is requested; the first fetch to any cacheable address after reset misses.
- R2: A fetch to a valid line returns the addressed word with `fetch_stall` low in the cycle the request is presented, and it issues no bus command; a bus command is only ever started for a fetch that is stalled.
- R3: A cacheable miss stalls the fetch and issues exactly one command with length equal to the words per line and the fetch address with its line-offset bits cleared; response beat i is stored as word i of the line, and once the last beat is taken the fetch completes as a hit.
- R4: A fetch matching an uncached window issues a command of length 1 at the fetch address with bits [1:0] cleared, and it completes with the response word in the cycle after the response beat; it allocates nothing, so repeating it issues another command.
- R5: Each set has a victim pointer that is 0 after reset and advances by one (modulo the way count) on every line fill; a tag never hits in two ways at once.
- R6: If any beat of a line fill carries the error flag, the line stays invalid, the fetch completes with `fetch_err` high in the cycle after the last beat, the victim pointer still advances, and a repeat of the fetch misses again.
- R7: A one-word uncached read whose response carries the error flag completes the fetch with `fetch_err` high.
- R8: While `cmd_val` is high and `cmd_ack` is low, `cmd_val`, `cmd_addr` and `cmd_plen` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request from the processor |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_stall | output | 1 | Fetch not yet served, processor must hold |
| fetch_rdata | output | 32 | Fetched instruction word |
| fetch_err | output | 1 | Fetch ended with a bus error |
| cmd_val | output | 1 | Read command valid |
| cmd_ack | input | 1 | Read command accepted |
| cmd_addr | output | 32 | Word-aligned byte address of the read |
| cmd_plen | output | 8 | Read length in words |
| rsp_val | input | 1 | Response beat valid |
| rsp_ack | output | 1 | Ready to take a response beat |
| rsp_data | input | 32 | Response word |
| rsp_err | input | 1 | Response error flag |
| rsp_eop | input | 1 | Last beat of the response |

## Verification
The assertions take for granted that the processor holds its request and address steady while stalled. They also take for granted that the bus answers a fill command with exactly the line's word count and an uncached command with one beat whose `rsp_eop` is set. The bench's fetch driver only drops `fetch_req` after the cycle in which the stall is released. Its bus responder reads the length from the accepted command and emits exactly that many beats. It inserts random acknowledge delays and gaps between beats, and it only injects errors on beats of a transaction that is already in progress.

// File: rtl/icache_ctl.sv
module icache_ctl #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int WAYS  = 2,
  parameter int NREG  = 1,
  parameter logic [NREG*32-1:0] UC_BASE = 32'hF000_0000,
  parameter logic [NREG*32-1:0] UC_MASK = 32'hF000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_req,
  input  logic [31:0] fetch_addr,
  output logic        fetch_stall,
  output logic [31:0] fetch_rdata,
  output logic        fetch_err,
  output logic        cmd_val,
  input  logic        cmd_ack,
  output logic [31:0] cmd_addr,
  output logic [7:0]  cmd_plen,
  input  logic        rsp_val,
  output logic        rsp_ack,
  input  logic [31:0] rsp_data,
  input  logic        rsp_err,
  input  logic        rsp_eop
);
  localparam int WOB = $clog2(WORDS);
  localparam int IXB = $clog2(LINES);
  localparam int TGW = 30 - WOB - IXB;
  localparam int WYB = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int DAW = $clog2(WAYS * LINES * WORDS);
  localparam int TAW = $clog2(WAYS * LINES);

  typedef enum logic [2:0] {S_IDLE, S_FCMD, S_FRSP, S_UCMD, S_URSP, S_DONE} st_t;
  st_t st;

  logic [31:0]    dmem [WAYS*LINES*WORDS];
  logic [TGW-1:0] tmem [WAYS*LINES];
  logic [WAYS*LINES-1:0] vbits;
  logic [WYB-1:0] vptr [LINES];

  logic [IXB-1:0] idx;
  logic [WOB-1:0] wsel;
  logic [TGW-1:0] tag;
  assign idx  = fetch_addr[2+WOB +: IXB];
  assign wsel = fetch_addr[2 +: WOB];
  assign tag  = fetch_addr[31 -: TGW];

  logic [WAYS-1:0] hitv;
  logic [WYB-1:0]  hway;
  logic            hit, uc;
  logic [DAW-1:0]  rix;
  logic [TAW-1:0]  vix;

  always_comb begin
    hway = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitv[w] = vbits[TAW'(w * LINES + int'(idx))] && (tmem[TAW'(w * LINES + int'(idx))] == tag);
      if (hitv[w]) hway = WYB'(w);
    end
    uc = 1'b0;
    for (int r = 0; r < NREG; r++)
      if ((fetch_addr & UC_MASK[r*32 +: 32]) == UC_BASE[r*32 +: 32]) uc = 1'b1;
    rix = DAW'((int'(hway) * LINES + int'(idx)) * WORDS + int'(wsel));
    vix = TAW'(int'(vptr[idx]) * LINES + int'(idx));
  end
  assign hit = |hitv;

  logic [31:0]    maddr, dbuf;
  logic [IXB-1:0] midx;
  logic [TGW-1:0] mtag;
  logic [WYB-1:0] mway;
  logic [WOB:0]   cnt;
  logic           ferr, derr;
  logic [DAW-1:0] fix;
  logic [TAW-1:0] mix;
  logic           last_ok;

  assign fix     = DAW'((int'(mway) * LINES + int'(midx)) * WORDS + int'(cnt));
  assign mix     = TAW'(int'(mway) * LINES + int'(midx));
  assign last_ok = !ferr && !rsp_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      vbits <= '0;
      for (int i = 0; i < LINES; i++) vptr[i] <= '0;
      maddr <= '0;
      midx  <= '0;
      mtag  <= '0;
      mway  <= '0;
      cnt   <= '0;
      ferr  <= 1'b0;
      dbuf  <= '0;
      derr  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (fetch_req && uc) begin
            maddr <= {fetch_addr[31:2], 2'b00};
            st    <= S_UCMD;
          end else if (fetch_req && !hit) begin
            maddr       <= {fetch_addr[31:2+WOB], {(2+WOB){1'b0}}};
            midx        <= idx;
            mtag        <= tag;
            mway        <= vptr[idx];
            vbits[vix]  <= 1'b0;
            cnt         <= '0;
            ferr        <= 1'b0;
            st          <= S_FCMD;
          end
        end
        S_FCMD: if (cmd_ack) st <= S_FRSP;
        S_FRSP: if (rsp_val) begin
          cnt  <= cnt + 1'b1;
          ferr <= ferr | rsp_err;
          if (rsp_eop) begin
            if (WAYS > 1) vptr[midx] <= vptr[midx] + 1'b1;
            if (last_ok) begin
              vbits[mix] <= 1'b1;
              st         <= S_IDLE;
            end else begin
              dbuf <= '0;
              derr <= 1'b1;
              st   <= S_DONE;
            end
          end
        end
        S_UCMD: if (cmd_ack) st <= S_URSP;
        S_URSP: if (rsp_val) begin
          dbuf <= rsp_data;
          derr <= rsp_err;
          if (rsp_eop) st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FRSP && rsp_val) dmem[fix] <= rsp_data;
    if (st == S_FRSP && rsp_val && rsp_eop && last_ok) tmem[mix] <= mtag;
  end

  assign fetch_stall = fetch_req && (st != S_DONE) && !(st == S_IDLE && hit && !uc);
  assign fetch_rdata = (st == S_DONE) ? dbuf : dmem[rix];
  assign fetch_err   = (st == S_DONE) && derr;
  assign cmd_val     = (st == S_FCMD) || (st == S_UCMD);
  assign cmd_addr    = maddr;
  assign cmd_plen    = (st == S_FCMD) ? 8'(WORDS) : 8'd1;
  assign rsp_ack     = (st == S_FRSP) || (st == S_URSP);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && !cmd_ack |=> cmd_val && $stable(cmd_addr) && $stable(cmd_plen)); // R8
  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && cmd_plen == 8'(WORDS) |-> cmd_addr[2+WOB-1:0] == '0); // R3
  AST_UC_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && cmd_plen != 8'(WORDS) |-> cmd_plen == 8'd1 && cmd_addr[1:0] == 2'b00); // R4
  AST_CMD_FROM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_val) |-> $past(fetch_req && fetch_stall)); // R2
  AST_ONE_HIT_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv)); // R5
  AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> fetch_req && !fetch_stall); // R6
endmodule

// File: tb/icache_ctl_bench.sv
module icache_ctl_bench;
  logic        clk = 0, rst_n = 0;
  logic        fetch_req = 0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_stall, fetch_err;
  logic [31:0] fetch_rdata;
  logic        cmd_val, cmd_ack = 0;
  logic [31:0] cmd_addr;
  logic [7:0]  cmd_plen;
  logic        rsp_val = 0, rsp_ack, rsp_err = 0, rsp_eop = 0;
  logic [31:0] rsp_data = '0;

  always #4 clk = ~clk;

  icache_ctl u_icache_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_stall(fetch_stall), .fetch_rdata(fetch_rdata), .fetch_err(fetch_err),
    .cmd_val(cmd_val), .cmd_ack(cmd_ack), .cmd_addr(cmd_addr), .cmd_plen(cmd_plen),
    .rsp_val(rsp_val), .rsp_ack(rsp_ack), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_eop(rsp_eop));

  int nchk = 0, nfail = 0;
  int ncmd = 0, err_beat = -1;
  logic [31:0] last_addr = '0;
  logic [7:0]  last_plen = '0;

  typedef struct { logic [31:0] data; logic err; string req; } exp_t;
  exp_t expq[$];

  function automatic logic [31:0] memw(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return {w[15:0], w[31:16]} ^ 32'hA5A5_1234;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_val) begin
        logic [31:0] a0;
        logic [7:0]  pl;
        a0 = cmd_addr;
        pl = cmd_plen;
        for (int d = 0; d < ncmd % 3; d++) begin
          @(negedge clk);
          chk(cmd_val && cmd_addr == a0 && cmd_plen == pl, "R8 command held", cmd_addr, a0);
        end
        cmd_ack = 1;
        @(negedge clk);
        cmd_ack = 0;
        last_addr = a0;
        last_plen = pl;
        for (int i = 0; i < int'(pl); i++) begin
          if (i % 2 == 1) @(negedge clk);
          rsp_val  = 1;
          rsp_data = memw(a0 + 32'(4 * i));
          rsp_err  = (i == err_beat);
          rsp_eop  = (i == int'(pl) - 1);
          while (!rsp_ack) @(negedge clk);
          @(negedge clk);
          rsp_val = 0;
          rsp_err = 0;
          rsp_eop = 0;
        end
        err_beat = -1;
        ncmd++;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && fetch_req && !fetch_stall) begin
      if (expq.size() == 0) begin
        chk(0, "unexpected completion", fetch_rdata, 32'h0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(fetch_err == e.err, {e.req, " error flag"}, 32'(fetch_err), 32'(e.err));
        if (!e.err) chk(fetch_rdata == e.data, {e.req, " data"}, fetch_rdata, e.data);
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input int ecmd, input logic [31:0] caddr,
                       input logic [7:0] plen, input logic eerr, input string req);
    exp_t e;
    int c0, stalls;
    e.data = memw(a); e.err = eerr; e.req = req;
    expq.push_back(e);
    c0 = ncmd;
    stalls = 0;
    @(posedge clk); #1;
    fetch_req = 1; fetch_addr = a;
    forever begin
      @(negedge clk);
      if (!fetch_stall) break;
      stalls++;
    end
    @(posedge clk); #1;
    fetch_req = 0;
    chk((ecmd > 0) ? (stalls > 0) : (stalls == 0), {req, " stall"}, 32'(stalls), 32'(ecmd));
    chk(ncmd - c0 == ecmd, {req, " command count"}, 32'(ncmd - c0), 32'(ecmd));
    if (ecmd > 0) begin
      chk(last_addr == caddr, {req, " command address"}, last_addr, caddr);
      chk(last_plen == plen, {req, " command length"}, 32'(last_plen), 32'(plen));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(!cmd_val && !rsp_ack && !fetch_stall, "R1 reset outputs", {29'b0, cmd_val, rsp_ack, fetch_stall}, 32'h0);
    // R1 R3: cold miss, fill of set 3 into way 0
    fetch(32'h0000_0034, 1, 32'h0000_0030, 8'd4, 0, "R1 R3 cold miss");
    // R2: hits in every word of the line
    fetch(32'h0000_0030, 0, 0, 0, 0, "R2 hit word0");
    fetch(32'h0000_0038, 0, 0, 0, 0, "R2 hit word2");
    fetch(32'h0000_003C, 0, 0, 0, 0, "R2 hit word3");
    // R5: round robin in set 3
    fetch(32'h0000_0130, 1, 32'h0000_0130, 8'd4, 0, "R5 fill way1");
    fetch(32'h0000_0034, 0, 0, 0, 0, "R5 way0 kept");
    fetch(32'h0000_013C, 0, 0, 0, 0, "R2 hit way1");
    fetch(32'h0000_0238, 1, 32'h0000_0230, 8'd4, 0, "R5 evict way0");
    fetch(32'h0000_0130, 0, 0, 0, 0, "R5 way1 kept");
    fetch(32'h0000_0030, 1, 32'h0000_0030, 8'd4, 0, "R5 refill evicts way1");
    fetch(32'h0000_0230, 0, 0, 0, 0, "R5 way0 kept");
    fetch(32'h0000_0134, 1, 32'h0000_0130, 8'd4, 0, "R5 evicted line misses");
    // R4: uncached window, no allocation
    fetch(32'hF000_0046, 1, 32'hF000_0044, 8'd1, 0, "R4 uncached read");
    fetch(32'hF000_0044, 1, 32'hF000_0044, 8'd1, 0, "R4 no allocation");
    // R6: fill error in set 0
    err_beat = 2;
    fetch(32'h0000_0504, 1, 32'h0000_0500, 8'd4, 1, "R6 fill error");
    fetch(32'h0000_0504, 1, 32'h0000_0500, 8'd4, 0, "R6 line left invalid");
    fetch(32'h0000_0608, 1, 32'h0000_0600, 8'd4, 0, "R6 pointer advanced fill");
    fetch(32'h0000_050C, 0, 0, 0, 0, "R6 pointer advanced hit");
    // R7: uncached error
    err_beat = 0;
    fetch(32'hF000_0100, 1, 32'hF000_0100, 8'd1, 1, "R7 uncached error");
    fetch(32'h0000_0600, 0, 0, 0, 0, "R2 hit after error");
    repeat (4) @(posedge clk);
    chk(expq.size() == 0, "scoreboard drained", 32'(expq.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule